// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execute stage for a 32-bit load/store RISC core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift amount, the 6-bit primary opcode and the 6-bit function code. It registers four outputs: the 32-bit result, an overflow-trap request, a destination write enable and an illegal-instruction flag.

Register-form operations use opcode 0 and are picked by the function code. Immediate-form operations are picked by the opcode. The block widens the immediate internally. It sign-extends for the arithmetic and compare forms and zero-extends for the logical forms.

Only the signed add and subtract forms can raise the trap. When they do, the write enable is withheld so the destination register keeps its old value. The trap handler is outside this block.

Top module: `int_alu_trap`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation is registered, `result` is 0 and `ovf_trap`, `wr_en` and `illegal` are all 0.
- R2: All outputs are registered. An operation presented on the inputs before a rising clock edge appears on the outputs after that edge, and is replaced by the next operation one edge later.
- R3: Add (opcode 0, funct 0x20), subtract (opcode 0, funct 0x22) and add-immediate (opcode 0x08) set `ovf_trap` to 1 on signed two's-complement overflow. In that case `wr_en` is 0 and `result` holds the wrapped 32-bit value.
- R4: With opcode 0, funct 0x20 gives a+b, 0x22 gives a-b, 0x24 gives a&b, 0x25 gives a|b, 0x26 gives a^b and 0x27 gives ~(a|b).
- R5: Add-immediate (opcode 0x08) and set-less-than-immediate (opcode 0x0A) sign-extend `imm` bit 15 into the upper 16 bits before use.
- R6: AND-immediate (opcode 0x0C) and OR-immediate (opcode 0x0D) fill the upper 16 bits of the immediate with zeros.
- R7: Set-less-than (opcode 0, funct 0x2A) and its immediate form compare as signed two's-complement numbers. The result is 1 when the first operand is smaller and 0 otherwise, including when the operands are equal.
- R8: Shift-left (opcode 0, funct 0x00) and shift-right (opcode 0, funct 0x02) shift `op_b` by `shamt` and fill the vacated bits with zeros. `op_a` is not used.
- R9: Any other opcode, and any other function code under opcode 0, gives `result` 0, `illegal` 1, `wr_en` 0 and `ovf_trap` 0.
- R10: A legal operation that does not overflow sets `wr_en` to 1 and `ovf_trap` to 0. Logical, compare and shift operations never trap, whatever their operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First source operand (rs) |
| op_b | input | 32 | Second source operand (rt); shifted value for shifts |
| imm | input | 16 | Immediate field of immediate-form operations |
| shamt | input | 5 | Shift amount for register-form shifts |
| opcode | input | 6 | Primary opcode |
| funct | input | 6 | Function code, used when opcode is 0 |
| result | output | 32 | Registered operation result |
| ovf_trap | output | 1 | Registered overflow-trap request |
| wr_en | output | 1 | Registered destination write enable |
| illegal | output | 1 | Registered illegal-instruction flag |

## Verification
Every result, and each of the three flags, appears exactly one rising edge after its operands and codes are presented. The bench drives each operation on a falling edge. It compares all four outputs at the following falling edge, half a period after the capturing edge and before any new stimulus is registered. A back-to-back scenario changes the operation on every cycle and checks that each output slot holds only its own operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int SHW    = $clog2(XLEN);
    localparam int CODE_W = 6;

    localparam logic [CODE_W-1:0] OPC_REG  = 6'h00;
    localparam logic [CODE_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [CODE_W-1:0] OPC_SLTI = 6'h0A;
    localparam logic [CODE_W-1:0] OPC_ANDI = 6'h0C;
    localparam logic [CODE_W-1:0] OPC_ORI  = 6'h0D;

    localparam logic [CODE_W-1:0] FN_SLL = 6'h00;
    localparam logic [CODE_W-1:0] FN_SRL = 6'h02;
    localparam logic [CODE_W-1:0] FN_ADD = 6'h20;
    localparam logic [CODE_W-1:0] FN_SUB = 6'h22;
    localparam logic [CODE_W-1:0] FN_AND = 6'h24;
    localparam logic [CODE_W-1:0] FN_OR  = 6'h25;
    localparam logic [CODE_W-1:0] FN_XOR = 6'h26;
    localparam logic [CODE_W-1:0] FN_NOR = 6'h27;
    localparam logic [CODE_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOR,
        ALU_SLT,
        ALU_SLL,
        ALU_SRL,
        ALU_NONE
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    use_imm;
        logic    sign_ext;
        logic    trap_en;
        logic    bad;
    } alu_ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            ovf_trap;
        logic            wr_en;
        logic            illegal;
    } alu_out_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output alu_ctrl_t         ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.op       = ALU_NONE;
        ctrl.bad      = 1'b0;
        unique case (opcode)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD: begin ctrl.op = ALU_ADD; ctrl.trap_en = 1'b1; end
                    FN_SUB: begin ctrl.op = ALU_SUB; ctrl.trap_en = 1'b1; end
                    FN_AND: ctrl.op = ALU_AND;
                    FN_OR:  ctrl.op = ALU_OR;
                    FN_XOR: ctrl.op = ALU_XOR;
                    FN_NOR: ctrl.op = ALU_NOR;
                    FN_SLT: ctrl.op = ALU_SLT;
                    FN_SLL: ctrl.op = ALU_SLL;
                    FN_SRL: ctrl.op = ALU_SRL;
                    default: ctrl.bad = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                ctrl.op       = ALU_ADD;
                ctrl.use_imm  = 1'b1;
                ctrl.sign_ext = 1'b1;
                ctrl.trap_en  = 1'b1;
            end
            OPC_SLTI: begin
                ctrl.op       = ALU_SLT;
                ctrl.use_imm  = 1'b1;
                ctrl.sign_ext = 1'b1;
            end
            OPC_ANDI: begin
                ctrl.op      = ALU_AND;
                ctrl.use_imm = 1'b1;
            end
            OPC_ORI: begin
                ctrl.op      = ALU_OR;
                ctrl.use_imm = 1'b1;
            end
            default: ctrl.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
    import alu_pkg::*;
#(
    parameter int W_IN  = IMM_W,
    parameter int W_OUT = XLEN
) (
    input  logic [W_IN-1:0]  imm,
    input  logic             sign_ext,
    output logic [W_OUT-1:0] imm_wide
);

    localparam int PAD = W_OUT - W_IN;

    logic fill;

    always_comb begin
        fill     = sign_ext & imm[W_IN-1];
        imm_wide = {{PAD{fill}}, imm};
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = SHW
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  sh,
    output logic [W-1:0]   y,
    output logic           ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         add_ovf;
    logic         sub_ovf;
    logic         lt;

    always_comb begin
        sum     = a + b;
        diff    = a - b;
        add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        lt      = $signed(a) < $signed(b);
        y       = '0;
        ovf     = 1'b0;
        unique case (op)
            ALU_ADD: begin y = sum;  ovf = add_ovf; end
            ALU_SUB: begin y = diff; ovf = sub_ovf; end
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            ALU_SLL: y = b << sh;
            ALU_SRL: y = b >> sh;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SHW-1:0]    shamt,
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output logic [XLEN-1:0]   result,
    output logic              ovf_trap,
    output logic              wr_en,
    output logic              illegal
);

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] core_y;
    logic            core_ovf;
    alu_out_t        out_d;
    alu_out_t        out_q;

    alu_decode i_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    alu_imm_ext #(.W_IN(IMM_W), .W_OUT(XLEN)) i_imm_ext (
        .imm      (imm),
        .sign_ext (ctrl.sign_ext),
        .imm_wide (imm_wide)
    );

    assign src_b = ctrl.use_imm ? imm_wide : op_b;

    alu_core #(.W(XLEN), .SW(SHW)) i_core (
        .op  (ctrl.op),
        .a   (op_a),
        .b   (src_b),
        .sh  (shamt),
        .y   (core_y),
        .ovf (core_ovf)
    );

    always_comb begin
        out_d          = '0;
        out_d.illegal  = ctrl.bad;
        out_d.result   = ctrl.bad ? '0 : core_y;
        out_d.ovf_trap = !ctrl.bad && ctrl.trap_en && core_ovf;
        out_d.wr_en    = !ctrl.bad && !out_d.ovf_trap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result   = out_q.result;
    assign ovf_trap = out_q.ovf_trap;
    assign wr_en    = out_q.wr_en;
    assign illegal  = out_q.illegal;

endmodule

// File: rtl/int_alu_trap_checker.sv
module int_alu_trap_checker
    import alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] opcode,
    input logic [CODE_W-1:0] funct,
    input logic [XLEN-1:0]   result,
    input logic              ovf_trap,
    input logic              wr_en,
    input logic              illegal
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (result == '0 && !ovf_trap && !wr_en && !illegal)); // R1

    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en); // R3

    AST_TRAP_ONLY_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ovf_trap) |->
            ($past(opcode) == OPC_ADDI ||
             ($past(opcode) == OPC_REG &&
              ($past(funct) == FN_ADD || $past(funct) == FN_SUB)))); // R10

    AST_ZERO_FILL_LOGIC_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rst_n) && $past(opcode) == OPC_ANDI) |-> result[XLEN-1:IMM_W] == '0); // R6

    AST_COMPARE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rst_n) && ($past(opcode) == OPC_SLTI ||
         ($past(opcode) == OPC_REG && $past(funct) == FN_SLT)))
            |-> result[XLEN-1:1] == '0); // R7

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0 && !wr_en && !ovf_trap)); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, wr_en, illegal})); // R10

endmodule

bind int_alu_trap int_alu_trap_checker i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .funct    (funct),
    .result   (result),
    .ovf_trap (ovf_trap),
    .wr_en    (wr_en),
    .illegal  (illegal)
);

// File: tb/test_int_alu_trap.sv
module test_int_alu_trap;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu_trap i_int_alu_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .imm      (imm),
        .shamt    (shamt),
        .opcode   (opcode),
        .funct    (funct),
        .result   (result),
        .ovf_trap (ovf_trap),
        .wr_en    (wr_en),
        .illegal  (illegal)
    );

    task automatic expect_out(input string req, input logic [31:0] er,
                              input logic et, input logic ew, input logic ei);
        checks++;
        if (result !== er || ovf_trap !== et || wr_en !== ew || illegal !== ei) begin
            errors++;
            $display("FAIL %s: got res=%h trap=%b wr=%b ill=%b, expected res=%h trap=%b wr=%b ill=%b",
                     req, result, ovf_trap, wr_en, illegal, er, et, ew, ei);
        end
    endtask

    task automatic drive(input logic [5:0] opc, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        opcode = opc; funct = fn; op_a = a; op_b = b; imm = im; shamt = sh;
    endtask

    // drive at a falling edge, result registered at the next rising edge,
    // sampled at the following falling edge
    task automatic run_op(input string req, input logic [5:0] opc, input logic [5:0] fn,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [4:0] sh,
                          input logic [31:0] er, input logic et, input logic ew, input logic ei);
        drive(opc, fn, a, b, im, sh);
        @(negedge clk);
        expect_out(req, er, et, ew, ei);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(6'h00, 6'h20, 32'd1, 32'd2, 16'h0, 5'd0);
        repeat (3) @(negedge clk);
        expect_out("R1 during reset", 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        expect_out("R1 after release", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reg_arith();
        run_op("R4 add",        6'h00, 6'h20, 32'd5, 32'd7, 16'h0, 5'd0, 32'd12, 1'b0, 1'b1, 1'b0);
        run_op("R4 sub neg",    6'h00, 6'h22, 32'd3, 32'd5, 16'h0, 5'd0, 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0);
        run_op("R10 add -1+-1", 6'h00, 6'h20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0,
               32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_logic();
        run_op("R4 and", 6'h00, 6'h24, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 16'h0, 5'd0, 32'h00F0_00F0, 1'b0, 1'b1, 1'b0);
        run_op("R4 or",  6'h00, 6'h25, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 16'h0, 5'd0, 32'hFFF0_FFF0, 1'b0, 1'b1, 1'b0);
        run_op("R4 xor", 6'h00, 6'h26, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 16'h0, 5'd0, 32'hFF00_FF00, 1'b0, 1'b1, 1'b0);
        run_op("R4 nor", 6'h00, 6'h27, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 16'h0, 5'd0, 32'h000F_000F, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_overflow();
        run_op("R3 add pos ovf",  6'h00, 6'h20, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        run_op("R3 sub neg ovf",  6'h00, 6'h22, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run_op("R3 addi ovf",     6'h08, 6'h3F, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        run_op("R3 addi neg ovf", 6'h08, 6'h00, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run_op("R10 nor extremes no trap", 6'h00, 6'h27, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0,
               32'h0000_0000, 1'b0, 1'b1, 1'b0);
        run_op("R10 slt extremes no trap", 6'h00, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0,
               32'h0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_imm_sign();
        run_op("R5 addi -1",    6'h08, 6'h00, 32'h10, 32'hDEAD_BEEF, 16'hFFFF, 5'd0, 32'h0000_000F, 1'b0, 1'b1, 1'b0);
        run_op("R5 addi 0x8000",6'h08, 6'h00, 32'h0, 32'h0, 16'h8000, 5'd0, 32'hFFFF_8000, 1'b0, 1'b1, 1'b0);
        run_op("R5 addi pos",   6'h08, 6'h00, 32'd100, 32'h0, 16'h7FFF, 5'd0, 32'd32867, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_imm_zero();
        run_op("R6 andi", 6'h0C, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, 32'h0000_8001, 1'b0, 1'b1, 1'b0);
        run_op("R6 ori",  6'h0D, 6'h00, 32'h1234_0000, 32'hFFFF_FFFF, 16'hF00F, 5'd0, 32'h1234_F00F, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_compare();
        run_op("R7 slt neg<pos",  6'h00, 6'h2A, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 32'd1, 1'b0, 1'b1, 1'b0);
        run_op("R7 slt pos<neg",  6'h00, 6'h2A, 32'd1, 32'h8000_0000, 16'h0, 5'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        run_op("R7 slt equal",    6'h00, 6'h2A, 32'd9, 32'd9, 16'h0, 5'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        run_op("R7 R5 slti -2<-1",6'h0A, 6'h00, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, 32'd1, 1'b0, 1'b1, 1'b0);
        run_op("R7 R5 slti 5<neg",6'h0A, 6'h00, 32'd5, 32'h0, 16'h8000, 5'd0, 32'd0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_shift();
        run_op("R8 sll by 1",   6'h00, 6'h00, 32'hFFFF_FFFF, 32'h8000_0001, 16'h0, 5'd1,  32'h0000_0002, 1'b0, 1'b1, 1'b0);
        run_op("R8 sll by 0",   6'h00, 6'h00, 32'hAAAA_AAAA, 32'h0000_1234, 16'h0, 5'd0,  32'h0000_1234, 1'b0, 1'b1, 1'b0);
        run_op("R8 srl by 31",  6'h00, 6'h02, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 5'd31, 32'h0000_0001, 1'b0, 1'b1, 1'b0);
        run_op("R8 srl zero-in",6'h00, 6'h02, 32'h0, 32'hF000_0000, 16'h0, 5'd4,  32'h0F00_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_illegal();
        run_op("R9 bad funct",  6'h00, 6'h21, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        run_op("R9 bad opcode", 6'h3F, 6'h20, 32'd5, 32'd7, 16'h1, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        run_op("R9 mult code",  6'h00, 6'h18, 32'd3, 32'd4, 16'h0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_back_to_back();
        drive(6'h00, 6'h20, 32'd1, 32'd2, 16'h0, 5'd0);
        @(negedge clk);
        expect_out("R2 slot 1 add", 32'd3, 1'b0, 1'b1, 1'b0);
        drive(6'h00, 6'h20, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 5'd0);
        @(negedge clk);
        expect_out("R2 slot 2 trap", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
        drive(6'h0D, 6'h00, 32'h0, 32'h0, 16'h00FF, 5'd0);
        @(negedge clk);
        expect_out("R2 slot 3 ori", 32'h0000_00FF, 1'b0, 1'b1, 1'b0);
        drive(6'h01, 6'h00, 32'h0, 32'h0, 16'h0, 5'd0);
        #(CLK_PERIOD/4);
        expect_out("R2 before edge holds prior", 32'h0000_00FF, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        expect_out("R2 slot 4 illegal", 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_reg_arith();
        t_logic();
        t_overflow();
        t_imm_sign();
        t_imm_zero();
        t_compare();
        t_shift();
        t_illegal();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule